// File: doc/BRIEF.md
# Streaming Packet Byte-Order Swapper

The block sits in a packet stream between an upstream producer and a downstream consumer. Each beat carries a data word, an empty count, start and end markers, and a valid/ready handshake. One register stage sits between the two sides. When the swap control is on, every byte lane of each data word leaves in reversed order. When it is off, the words pass through unchanged.

The swap choice is made once for each packet, when its first beat is accepted. It then holds for every beat up to the end marker. Software may change the control in the middle of a packet, and that packet is still never swapped in part.

A small register port sits beside the data path. It holds the swap control and a read-only count of the packets delivered downstream. Register reads return their data one cycle after the read strobe.

Top module: `stream_byte_swapper`

## Requirements
- R1: After reset, out_valid is low, the swap control reads 0 and the packet count reads 0.
- R2: in_ready is high whenever out_ready is high or the output stage holds no beat. It is low when a held beat is stalled by out_ready low.
- R3: An input beat accepted at a clock edge (in_valid and in_ready both high) appears on the output at that same edge, with out_valid high. Its data, empty, start and end markers come out together, and beats leave in arrival order.
- R4: While out_valid is high and out_ready is low, all output fields stay unchanged.
- R5: The swap control is bit 0 of the register at byte offset 0. When it applies, output byte lane k (bits 8k+7:8k) equals input lane NB-1-k. When it does not apply, the data is unchanged.
- R6: The control value present on the start-of-packet beat decides the whole packet. A control write made while a packet is in flight affects only later packets.
- R7: The empty field is forwarded unchanged on every beat.
- R8: The register at byte offset 4 counts packets delivered downstream. It adds one for each beat that has out_valid, out_ready and out_eop high, and wraps modulo 2^32.
- R9: reg_rdata presents the selected register one cycle after a cycle with reg_rd high, and is 0 otherwise. Bits 31:1 of the control register read as 0.
- R10: Writes to offset 4 leave the count unchanged. Reads of any offset other than 0 and 4 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_data | input | DATA_W | Input data word |
| in_empty | input | EMPTY_W | Unused byte count on the last beat |
| in_valid | input | 1 | Input beat qualifier |
| in_sop | input | 1 | First beat of a packet |
| in_eop | input | 1 | Last beat of a packet |
| in_ready | output | 1 | Block can accept an input beat |
| out_data | output | DATA_W | Output data word, possibly byte-reversed |
| out_empty | output | EMPTY_W | Forwarded empty count |
| out_valid | output | 1 | Output beat qualifier |
| out_sop | output | 1 | Forwarded start marker |
| out_eop | output | 1 | Forwarded end marker |
| out_ready | input | 1 | Downstream can accept a beat |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rd | input | 1 | Register read strobe |
| reg_rdata | output | 32 | Register read data, one cycle after the strobe |

## Verification
An input beat accepted at one edge is on the output pins right after that edge. The bench samples both sides of each handshake one nanosecond before the edge, so the scoreboard pops its expected beat only on a real downstream transfer. A directed case stalls the output and checks the latency, the ready drop and the stable hold half a cycle after the relevant edges. The count changes at the edge of the delivering handshake. Register data is due one edge after the strobe: the bench checks it is still 0 before that edge and holds the value after it. Count reads are issued only after the pipeline has drained, so the expected count is exact.

// File: rtl/stream_byte_swapper.sv
module stream_byte_swapper #(
  parameter int DATA_W  = 32,
  parameter int EMPTY_W = $clog2(DATA_W / 8),
  parameter int REG_AW  = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DATA_W-1:0]    in_data,
  input  logic [EMPTY_W-1:0]   in_empty,
  input  logic                 in_valid,
  input  logic                 in_sop,
  input  logic                 in_eop,
  output logic                 in_ready,
  output logic [DATA_W-1:0]    out_data,
  output logic [EMPTY_W-1:0]   out_empty,
  output logic                 out_valid,
  output logic                 out_sop,
  output logic                 out_eop,
  input  logic                 out_ready,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic                 reg_wr,
  input  logic [31:0]          reg_wdata,
  input  logic                 reg_rd,
  output logic [31:0]          reg_rdata
);
  localparam int NB = DATA_W / 8;
  localparam logic [REG_AW-1:0] OFS_CTRL = REG_AW'(0);
  localparam logic [REG_AW-1:0] OFS_CNT  = REG_AW'(4);

  logic              ctrl_en;
  logic              pkt_swap;
  logic              use_swap;
  logic              take;
  logic              deliver_eop;
  logic [DATA_W-1:0] reversed;
  logic [31:0]       pkt_cnt;

  assign in_ready    = out_ready | ~out_valid;
  assign take        = in_valid & in_ready;
  assign deliver_eop = out_valid & out_ready & out_eop;
  assign use_swap    = in_sop ? ctrl_en : pkt_swap;

  for (genvar g = 0; g < NB; g++) begin : g_lane
    assign reversed[8*g +: 8] = in_data[8*(NB-1-g) +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_swap <= 1'b0;
    end else if (take && in_sop) begin
      pkt_swap <= ctrl_en;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_empty <= '0;
      out_sop   <= 1'b0;
      out_eop   <= 1'b0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= use_swap ? reversed : in_data;
      out_empty <= in_empty;
      out_sop   <= in_sop;
      out_eop   <= in_eop;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en <= 1'b0;
    end else if (reg_wr && reg_addr == OFS_CTRL) begin
      ctrl_en <= reg_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_cnt <= '0;
    end else if (deliver_eop) begin
      pkt_cnt <= pkt_cnt + 32'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_addr)
        OFS_CTRL: reg_rdata <= {31'd0, ctrl_en};
        OFS_CNT:  reg_rdata <= pkt_cnt;
        default:  reg_rdata <= '0;
      endcase
    end else begin
      reg_rdata <= '0;
    end
  end

  p_accept_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_empty)
                                   && $stable(out_sop) && $stable(out_eop)));

  p_idle_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  p_empty_fwd_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_empty == $past(in_empty));

  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_eop) |=> pkt_cnt == $past(pkt_cnt) + 32'd1);

  p_cnt_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ready && out_eop) |=> $stable(pkt_cnt));

  p_resv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == OFS_CTRL) |=> reg_rdata[31:1] == 31'd0);

  p_no_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> reg_rdata == 32'd0);
endmodule

// File: tb/stream_byte_swapper_test.sv
`timescale 1ns/1ps
module stream_byte_swapper_test;
  localparam int DW = 32;
  localparam int NB = DW / 8;
  localparam int EW = 2;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic [EW-1:0] in_empty = '0;
  logic in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
  logic in_ready;
  logic [DW-1:0] out_data;
  logic [EW-1:0] out_empty;
  logic out_valid, out_sop, out_eop;
  logic out_ready = 1'b1;
  logic [AW-1:0] reg_addr = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  always #4 clk = ~clk;

  stream_byte_swapper #(.DATA_W(DW), .EMPTY_W(EW), .REG_AW(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .in_data(in_data), .in_empty(in_empty), .in_valid(in_valid),
    .in_sop(in_sop), .in_eop(in_eop), .in_ready(in_ready),
    .out_data(out_data), .out_empty(out_empty), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .out_ready(out_ready),
    .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rd(reg_rd), .reg_rdata(reg_rdata)
  );

  typedef struct packed {
    logic [DW-1:0] d;
    logic [EW-1:0] e;
    logic          s;
    logic          x;
  } beat_t;

  beat_t expq[$];
  int checks = 0;
  int fails = 0;
  int pkts_sent = 0;
  int bp_mode = 0;
  int cyc = 0;
  logic sw_en = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  function automatic logic [DW-1:0] flip(input logic [DW-1:0] w);
    logic [DW-1:0] r;
    for (int k = 0; k < NB; k++) r[8*k +: 8] = w[8*(NB-1-k) +: 8];
    return r;
  endfunction

  always @(negedge clk) begin
    cyc++;
    case (bp_mode)
      0: out_ready = 1'b1;
      1: out_ready = 1'($urandom % 2);
      2: out_ready = (cyc % 3) != 0;
      default: out_ready = 1'b0;
    endcase
  end

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) begin
          check(1'b0, "R3 unexpected beat", {28'd0, out_data, out_empty, out_sop, out_eop}, 64'd0);
        end else begin
          beat_t e;
          beat_t a;
          e = expq.pop_front();
          a = {out_data, out_empty, out_sop, out_eop};
          check(a == e, "R3/R5/R6/R7 beat", 64'(a), 64'(e));
        end
      end
    end
  end

  task automatic reg_write(input logic [AW-1:0] a, input logic [31:0] v);
    @(negedge clk);
    in_valid = 1'b0;
    reg_addr = a; reg_wdata = v; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
    if (a == 0) sw_en = v[0];
  endtask

  task automatic reg_read(input logic [AW-1:0] a, output logic [31:0] v);
    @(negedge clk);
    in_valid = 1'b0;
    reg_addr = a; reg_rd = 1'b1;
    #1;
    check(reg_rdata == 32'd0, "R9 data not early", 64'(reg_rdata), 64'd0);
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic send_pkt(input int nbeats, input int toggle_at, input bit idles);
    logic pswap = 1'b0;
    for (int b = 0; b < nbeats; b++) begin
      beat_t e;
      logic [DW-1:0] dat;
      logic [EW-1:0] emp;
      bit acc;
      if (b == toggle_at) reg_write(AW'(0), {31'd0, ~sw_en});
      if (idles && ($urandom % 3 == 0)) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
      dat = $urandom;
      emp = (b == nbeats - 1) ? EW'($urandom % NB) : '0;
      if (b == 0) pswap = sw_en;
      e.d = pswap ? flip(dat) : dat;
      e.e = emp; e.s = (b == 0); e.x = (b == nbeats - 1);
      expq.push_back(e);
      @(negedge clk);
      in_data = dat; in_empty = emp; in_sop = (b == 0); in_eop = (b == nbeats - 1); in_valid = 1'b1;
      acc = 1'b0;
      while (!acc) begin
        #3;
        acc = in_ready;
        @(posedge clk);
        if (!acc) @(negedge clk);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    pkts_sent++;
  endtask

  task automatic drain();
    int n = 0;
    while (expq.size() != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    check(expq.size() == 0, "R3 drain", 64'(expq.size()), 64'd0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] rv;
    beat_t e;
    logic [DW-1:0] held;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", 64'(out_valid), 64'd0);
    check(in_ready == 1'b1, "R2 ready when empty", 64'(in_ready), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    reg_read(AW'(0), rv);
    check(rv == 32'd0, "R1 control after reset", 64'(rv), 64'd0);
    reg_read(AW'(4), rv);
    check(rv == 32'd0, "R1 count after reset", 64'(rv), 64'd0);

    // R5: pass-through then swapped, no backpressure
    for (int p = 0; p < 4; p++) send_pkt(1 + p, -1, 1'b0);
    reg_write(AW'(0), 32'd1);
    for (int p = 0; p < 4; p++) send_pkt(2 + p, -1, 1'b0);
    drain();

    // R2/R3/R4: stalled output
    bp_mode = 3;
    @(negedge clk);
    held = 32'h1122_3344;
    e.d = flip(held); e.e = 2'd3; e.s = 1'b1; e.x = 1'b1;
    expq.push_back(e);
    in_data = held; in_empty = 2'd3; in_sop = 1'b1; in_eop = 1'b1; in_valid = 1'b1;
    #3;
    check(in_ready == 1'b1, "R2 ready with empty stage", 64'(in_ready), 64'd1);
    @(negedge clk);
    in_valid = 1'b0;
    pkts_sent++;
    #1;
    check(out_valid == 1'b1, "R3 one-stage latency", 64'(out_valid), 64'd1);
    check(in_ready == 1'b0, "R2 ready low when stalled", 64'(in_ready), 64'd0);
    check(out_data == 32'h4433_2211, "R5 lane reversal", 64'(out_data), 64'h44332211);
    repeat (3) @(negedge clk);
    #1;
    check(out_valid == 1'b1 && out_data == 32'h4433_2211 && out_empty == 2'd3,
          "R4 hold under stall", {31'd0, out_valid, out_data}, {31'd0, 1'b1, 32'h44332211});
    bp_mode = 0;
    drain();

    // R5/R7 under random backpressure and idle input
    bp_mode = 1;
    for (int p = 0; p < 6; p++) send_pkt(1 + (p % 5), -1, 1'b1);
    reg_write(AW'(0), 32'd0);
    for (int p = 0; p < 6; p++) send_pkt(2 + (p % 4), -1, 1'b1);
    drain();

    // R6: control toggled mid-packet
    bp_mode = 2;
    for (int p = 0; p < 6; p++) send_pkt(5, 1 + (p % 3), 1'b0);
    send_pkt(4, 0, 1'b0);
    drain();
    bp_mode = 0;

    // R8: count equals packets delivered
    reg_read(AW'(4), rv);
    check(rv == 32'(pkts_sent), "R8 packet count", 64'(rv), 64'(pkts_sent));

    // R10: write to count ignored, unmapped offset reads 0
    reg_write(AW'(4), 32'hDEAD_BEEF);
    reg_read(AW'(4), rv);
    check(rv == 32'(pkts_sent), "R10 count write ignored", 64'(rv), 64'(pkts_sent));
    reg_read(AW'(8), rv);
    check(rv == 32'd0, "R10 unmapped offset", 64'(rv), 64'd0);

    // R9: reserved bits
    reg_write(AW'(0), 32'hFFFF_FFFF);
    reg_read(AW'(0), rv);
    check(rv == 32'd1, "R9 reserved bits zero", 64'(rv), 64'd1);
    reg_write(AW'(0), 32'hFFFF_FFFE);
    reg_read(AW'(0), rv);
    check(rv == 32'd0, "R9 control cleared", 64'(rv), 64'd0);

    summary();
    $finish;
  end
endmodule